// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address when the translation cache has missed. It splits the address into a 10-bit top-table index, a 10-bit leaf-table index and a 12-bit byte offset within a 4 KB page. It then makes two dependent reads through a memory port that carries one request at a time. The first read fetches a top-table entry, which names the frame that holds the leaf table. The second read fetches the leaf entry, which names the data frame. Each table entry is 4 bytes wide, so a table holds 1024 entries and fills one page exactly.

A walk starts from the frame in the table base input, which points at the current process's top table. If the walk succeeds, the walker writes the leaf entry back with its referenced flag set, and also its modified flag on a write access. It then pulses a fill toward the translation cache. If the top entry or the leaf entry is not present, or a write reaches a leaf that does not allow writes, the walk ends with a one-cycle fault pulse. The pulse carries the virtual address and a fault class. Handling the fault and choosing pages to replace are left to software.

The entry format is as follows. Bits 31:12 hold a frame number. Bit 0 marks the entry present, bit 1 allows writes, bit 2 is the referenced flag and bit 3 is the modified flag.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, walk_ready is 1 and mem_req_valid, fill_valid and fault_valid are all 0. Whenever walk_ready is 1, no memory request is pending.
- R2: A walk accepted with walk_valid and walk_ready both high first reads the address formed by base frame bits 31:12, then virtual address bits 31:22, then two zero bits.
- R3: When the top entry is present, the second read uses the top entry's bits 31:12, then virtual address bits 21:12, then two zero bits.
- R4: The memory request holds valid, address, write flag and write data steady until mem_req_ready accepts it. No new request is raised while a read is still waiting for its mem_rsp_valid.
- R5: A top entry with bit 0 clear ends the walk with fault_valid and fault_kind = 1, with fault_vaddr equal to the virtual address. No further memory access is made.
- R6: A present top entry followed by a leaf entry with bit 0 clear ends the walk with fault_kind = 2 and no write.
- R7: A write access whose present leaf entry has bit 1 clear ends with fault_kind = 3 and no write. A read access to the same entry succeeds.
- R8: A successful walk writes exactly once, to the leaf entry's address. The data is the leaf entry with bit 2 set, and bit 3 also set for a write access. All other bits are kept.
- R9: The fill pulse is one cycle long and comes only after the write-back has been accepted. It carries fill_vpn = virtual address bits 31:12, fill_pfn = leaf bits 31:12, fill_writable = leaf bit 1, and fill_dirty = the modified flag as written back.
- R10: Each walk ends with exactly one fill pulse or one fault pulse, never both, and walk_ready is 1 in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_valid | input | 1 | Miss request to translate |
| walk_ready | output | 1 | Walker idle, request accepted this cycle |
| walk_vaddr | input | 32 | Virtual address that missed |
| walk_is_write | input | 1 | Access type of the missing access |
| table_base | input | 32 | Top-table base; bits 31:12 give its frame |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for write-back, 0 for read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry read from memory |
| fill_valid | output | 1 | Translation fill pulse |
| fill_vpn | output | 20 | Virtual page number filled |
| fill_pfn | output | 20 | Physical frame number filled |
| fill_writable | output | 1 | Write permission of the fill |
| fill_dirty | output | 1 | Modified flag of the fill |
| fault_valid | output | 1 | Fault pulse |
| fault_kind | output | 2 | 1 top absent, 2 leaf absent, 3 write denied |
| fault_vaddr | output | 32 | Virtual address that faulted |

## Verification
The checker watches the memory port on every cycle. It checks that a request stays steady while it is stalled, and that no request overlaps a read still waiting for its response. It checks that every write-back carries the present and referenced flags. It also checks that a fill always follows an accepted write-back within its walk, while a fault never does, and that the two pulses never coincide and always lead back to idle. The two read addresses, the three fault classes, the exact bits written back and the fill fields depend on the table contents and the virtual address, so only the bench's directed and random walks show them. The bench compares these against its own arithmetic.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  localparam int VA_W      = 32;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 10;
  localparam int ENTRY_B   = 4;
  localparam int SLOT_W    = $clog2(ENTRY_B);
  localparam int PFN_W     = VA_W - OFF_W;
  localparam int ENTRY_W   = 8 * ENTRY_B;
  localparam int TOP_LSB   = OFF_W + IDX_W;
  localparam int KIND_W    = 2;

  // Flag positions inside an entry
  localparam int F_PRESENT = 0;
  localparam int F_WRITE   = 1;
  localparam int F_REF     = 2;
  localparam int F_MOD     = 3;

  typedef logic [VA_W-1:0]    addr_t;
  typedef logic [ENTRY_W-1:0] entry_t;
  typedef logic [PFN_W-1:0]   pfn_t;
  typedef logic [IDX_W-1:0]   idx_t;

  typedef enum logic [KIND_W-1:0] {
    FK_NONE       = 2'd0,
    FK_TOP_ABSENT = 2'd1,
    FK_LEAF_ABSENT= 2'd2,
    FK_WRITE_DENY = 2'd3
  } fault_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_TOP,
    ST_WAIT_LEAF,
    ST_WRITEBACK,
    ST_FILL,
    ST_FAULT
  } walk_state_e;

  function automatic idx_t top_index(input addr_t va);
    return va[TOP_LSB +: IDX_W];
  endfunction

  function automatic idx_t leaf_index(input addr_t va);
    return va[OFF_W +: IDX_W];
  endfunction

  function automatic pfn_t page_of(input addr_t va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic pfn_t frame_of(input entry_t e);
    return e[ENTRY_W-1:OFF_W];
  endfunction

  function automatic addr_t slot_addr(input pfn_t frame, input idx_t idx);
    return {frame, idx, {SLOT_W{1'b0}}};
  endfunction

  function automatic entry_t touch_entry(input entry_t e, input logic wr);
    entry_t t;
    t = e;
    t[F_REF] = 1'b1;
    if (wr) t[F_MOD] = 1'b1;
    return t;
  endfunction

endpackage

// File: rtl/pgwalk_memreq.sv
module pgwalk_memreq
  import pgwalk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   issue,
  input  logic   issue_write,
  input  addr_t  issue_addr,
  input  entry_t issue_wdata,
  input  logic   mem_req_ready,
  output logic   mem_req_valid,
  output logic   mem_req_write,
  output addr_t  mem_req_addr,
  output entry_t mem_req_wdata,
  output logic   accept
);

  assign accept = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
    end else if (issue) begin
      mem_req_valid <= 1'b1;
      mem_req_write <= issue_write;
      mem_req_addr  <= issue_addr;
      mem_req_wdata <= issue_wdata;
    end else if (accept) begin
      mem_req_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pgwalk_entry_eval.sv
module pgwalk_entry_eval
  import pgwalk_pkg::*;
(
  input  entry_t      entry,
  input  logic        at_leaf,
  input  logic        is_write,
  output logic        usable,
  output fault_kind_e kind,
  output entry_t      wb_data
);

  logic present;
  logic deny;

  assign present = entry[F_PRESENT];
  assign deny    = at_leaf && is_write && !entry[F_WRITE];
  assign usable  = present && !deny;
  assign wb_data = touch_entry(entry, is_write);

  always_comb begin
    if (!present)   kind = at_leaf ? FK_LEAF_ABSENT : FK_TOP_ABSENT;
    else if (deny)  kind = FK_WRITE_DENY;
    else            kind = FK_NONE;
  end

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        walk_valid,
  input  addr_t       walk_vaddr,
  input  logic        walk_is_write,
  input  addr_t       table_base,
  input  logic        mem_rsp_valid,
  input  entry_t      mem_rsp_data,
  input  logic        mem_accept,
  input  logic        mem_req_write,
  input  logic        eval_usable,
  input  fault_kind_e eval_kind,
  input  entry_t      eval_wb,
  output logic        walk_ready,
  output logic        at_leaf,
  output logic        cur_write,
  output logic        issue,
  output logic        issue_write,
  output addr_t       issue_addr,
  output entry_t      issue_wdata,
  output logic        ev_start,
  output logic        ev_take,
  output logic        ev_wb_done,
  output logic        fill_valid,
  output pfn_t        fill_vpn,
  output pfn_t        fill_pfn,
  output logic        fill_writable,
  output logic        fill_dirty,
  output logic        fault_valid,
  output logic [KIND_W-1:0] fault_kind,
  output addr_t       fault_vaddr
);

  walk_state_e state_q, state_d;
  addr_t       va_q;
  logic        wr_q;
  addr_t       leaf_addr_q;
  entry_t      leaf_q;
  fault_kind_e kind_q, kind_d;
  logic        cap_leaf;

  assign walk_ready = (state_q == ST_IDLE);
  assign at_leaf    = (state_q == ST_WAIT_LEAF);
  assign cur_write  = wr_q;
  assign ev_start   = walk_ready && walk_valid;
  assign ev_take    = mem_rsp_valid &&
                      (state_q == ST_WAIT_TOP || state_q == ST_WAIT_LEAF);
  assign ev_wb_done = (state_q == ST_WRITEBACK) && mem_accept && mem_req_write;

  always_comb begin
    state_d     = state_q;
    kind_d      = kind_q;
    issue       = 1'b0;
    issue_write = 1'b0;
    issue_addr  = '0;
    issue_wdata = '0;
    cap_leaf    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (walk_valid) begin
          issue      = 1'b1;
          issue_addr = slot_addr(frame_of(table_base), top_index(walk_vaddr));
          state_d    = ST_WAIT_TOP;
        end
      end
      ST_WAIT_TOP: begin
        if (mem_rsp_valid) begin
          if (!eval_usable) begin
            kind_d  = eval_kind;
            state_d = ST_FAULT;
          end else begin
            issue      = 1'b1;
            issue_addr = slot_addr(frame_of(mem_rsp_data), leaf_index(va_q));
            state_d    = ST_WAIT_LEAF;
          end
        end
      end
      ST_WAIT_LEAF: begin
        if (mem_rsp_valid) begin
          if (!eval_usable) begin
            kind_d  = eval_kind;
            state_d = ST_FAULT;
          end else begin
            issue       = 1'b1;
            issue_write = 1'b1;
            issue_addr  = leaf_addr_q;
            issue_wdata = eval_wb;
            cap_leaf    = 1'b1;
            state_d     = ST_WRITEBACK;
          end
        end
      end
      ST_WRITEBACK: begin
        if (ev_wb_done) state_d = ST_FILL;
      end
      ST_FILL:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      leaf_addr_q <= '0;
      leaf_q      <= '0;
      kind_q      <= FK_NONE;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      if (ev_start) begin
        va_q <= walk_vaddr;
        wr_q <= walk_is_write;
      end
      if (state_q == ST_WAIT_TOP && issue) leaf_addr_q <= issue_addr;
      if (cap_leaf) leaf_q <= eval_wb;
    end
  end

  assign fill_valid    = (state_q == ST_FILL);
  assign fill_vpn      = page_of(va_q);
  assign fill_pfn      = frame_of(leaf_q);
  assign fill_writable = leaf_q[F_WRITE];
  assign fill_dirty    = leaf_q[F_MOD];
  assign fault_valid   = (state_q == ST_FAULT);
  assign fault_kind    = kind_q;
  assign fault_vaddr   = va_q;

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        walk_valid,
  output logic        walk_ready,
  input  logic [31:0] walk_vaddr,
  input  logic        walk_is_write,
  input  logic [31:0] table_base,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        fill_valid,
  output logic [19:0] fill_vpn,
  output logic [19:0] fill_pfn,
  output logic        fill_writable,
  output logic        fill_dirty,
  output logic        fault_valid,
  output logic [1:0]  fault_kind,
  output logic [31:0] fault_vaddr
);

  // Internal events, brought out for the checker
  logic        ev_start;
  logic        ev_take;
  logic        ev_wb_done;
  logic        mem_accept;

  logic        issue;
  logic        issue_write;
  addr_t       issue_addr;
  entry_t      issue_wdata;
  logic        at_leaf;
  logic        cur_write;
  logic        eval_usable;
  fault_kind_e eval_kind;
  entry_t      eval_wb;

  pgwalk_entry_eval u_eval (
    .entry    (mem_rsp_data),
    .at_leaf  (at_leaf),
    .is_write (cur_write),
    .usable   (eval_usable),
    .kind     (eval_kind),
    .wb_data  (eval_wb)
  );

  pgwalk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .walk_valid    (walk_valid),
    .walk_vaddr    (walk_vaddr),
    .walk_is_write (walk_is_write),
    .table_base    (table_base),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_accept    (mem_accept),
    .mem_req_write (mem_req_write),
    .eval_usable   (eval_usable),
    .eval_kind     (eval_kind),
    .eval_wb       (eval_wb),
    .walk_ready    (walk_ready),
    .at_leaf       (at_leaf),
    .cur_write     (cur_write),
    .issue         (issue),
    .issue_write   (issue_write),
    .issue_addr    (issue_addr),
    .issue_wdata   (issue_wdata),
    .ev_start      (ev_start),
    .ev_take       (ev_take),
    .ev_wb_done    (ev_wb_done),
    .fill_valid    (fill_valid),
    .fill_vpn      (fill_vpn),
    .fill_pfn      (fill_pfn),
    .fill_writable (fill_writable),
    .fill_dirty    (fill_dirty),
    .fault_valid   (fault_valid),
    .fault_kind    (fault_kind),
    .fault_vaddr   (fault_vaddr)
  );

  pgwalk_memreq u_req (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue         (issue),
    .issue_write   (issue_write),
    .issue_addr    (issue_addr),
    .issue_wdata   (issue_wdata),
    .mem_req_ready (mem_req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .accept        (mem_accept)
  );

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk
  import pgwalk_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        walk_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic        mem_rsp_valid,
  input logic        fill_valid,
  input logic        fault_valid,
  input logic [1:0]  fault_kind,
  input logic        ev_take,
  input logic        ev_wb_done
);

  logic rd_pend;
  logic wb_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      wb_seen <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready && !mem_req_write) rd_pend <= 1'b1;
      else if (mem_rsp_valid) rd_pend <= 1'b0;
      if (fill_valid || fault_valid) wb_seen <= 1'b0;
      else if (ev_wb_done) wb_seen <= 1'b1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ready |-> !mem_req_valid);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  // R4
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !mem_req_valid);

  // R8
  wb_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[F_REF] && mem_req_wdata[F_PRESENT]);

  // R9
  fill_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> wb_seen);

  // R5
  fault_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !wb_seen && fault_kind != 2'd0);

  // R10
  end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fault_valid));

  // R10
  back_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid || fault_valid |=> walk_ready);

  // R3
  take_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |-> rd_pend);

endmodule

bind pgwalk_top pgwalk_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .walk_ready    (walk_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .fill_valid    (fill_valid),
  .fault_valid   (fault_valid),
  .fault_kind    (fault_kind),
  .ev_take       (ev_take),
  .ev_wb_done    (ev_wb_done)
);

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_valid = 1'b0;
  logic        walk_ready;
  logic [31:0] walk_vaddr = '0;
  logic        walk_is_write = 1'b0;
  logic [31:0] table_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        fill_valid;
  logic [19:0] fill_vpn;
  logic [19:0] fill_pfn;
  logic        fill_writable;
  logic        fill_dirty;
  logic        fault_valid;
  logic [1:0]  fault_kind;
  logic [31:0] fault_vaddr;

  always #4 clk = ~clk;

  pgwalk_top u_pgwalk_top (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Table contents for the walk in progress
  logic [31:0] cur_base, cur_va, cur_top, cur_leaf;
  int rd_cnt, wr_cnt, bad_addr, hold_err, overlap_err;
  logic [31:0] wr_addr, wr_data;

  function automatic logic [31:0] exp_top_addr(logic [31:0] b, logic [31:0] va);
    return (b & 32'hFFFF_F000) | ((va >> 22) << 2);
  endfunction

  function automatic logic [31:0] exp_leaf_addr(logic [31:0] t, logic [31:0] va);
    return (t & 32'hFFFF_F000) | (((va >> 12) & 32'h3FF) << 2);
  endfunction

  function automatic logic [31:0] lookup(logic [31:0] a);
    if (a == exp_top_addr(cur_base, cur_va)) return cur_top;
    if (a == exp_leaf_addr(cur_top, cur_va)) return cur_leaf;
    bad_addr++;
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: random accept, random response delay
  initial begin
    logic        acc, acc_w, stall_prev, pend;
    logic [31:0] acc_a, prev_a;
    int          dly;
    stall_prev = 0; pend = 0; dly = 0; prev_a = '0;
    forever begin
      @(posedge clk);
      acc   = mem_req_valid && mem_req_ready;
      acc_w = mem_req_write;
      acc_a = mem_req_addr;
      if (rst_n) begin
        if (stall_prev && (!mem_req_valid || mem_req_addr != prev_a)) hold_err++;
        if (pend && mem_req_valid) overlap_err++;
        if (acc && acc_w) begin
          wr_cnt++;
          wr_addr = mem_req_addr;
          wr_data = mem_req_wdata;
        end
        if (acc && !acc_w) rd_cnt++;
      end
      stall_prev = mem_req_valid && !mem_req_ready;
      prev_a     = mem_req_addr;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (acc && !acc_w) begin
        pend = 1;
        dly  = int'($urandom % 3);
        mem_rsp_data = lookup(acc_a);
      end
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          pend = 0;
        end else dly--;
      end
      mem_req_ready = ($urandom % 3) != 0;
    end
  end

  task automatic run_walk(input logic [31:0] b, input logic [31:0] va, input bit wr,
                          input logic [31:0] te, input logic [31:0] le);
    int n;
    logic [1:0]  ek;
    logic [31:0] ewb;
    cur_base = b; cur_va = va; cur_top = te; cur_leaf = le;
    rd_cnt = 0; wr_cnt = 0; bad_addr = 0; hold_err = 0; overlap_err = 0;
    @(negedge clk);
    walk_valid = 1; walk_vaddr = va; walk_is_write = wr; table_base = b;
    @(posedge clk);
    while (!walk_ready) @(posedge clk);
    @(negedge clk);
    walk_valid = 0;
    walk_vaddr = $urandom; table_base = $urandom; walk_is_write = $urandom;
    n = 0;
    while (!(fill_valid || fault_valid) && n < 300) begin
      @(negedge clk); n++;
    end
    ek  = !te[0] ? 2'd1 : !le[0] ? 2'd2 : (wr && !le[1]) ? 2'd3 : 2'd0;
    ewb = le | 32'h4 | (wr ? 32'h8 : 32'h0);
    chk(n < 300, "R10 walk ends", n, 300);
    chk(!(fill_valid && fault_valid), "R10 one outcome", {fill_valid, fault_valid}, 0);
    // R2 R3: every read hit an expected table slot
    chk(bad_addr == 0, "R2/R3 read addresses", bad_addr, 0);
    chk(hold_err == 0 && overlap_err == 0, "R4 request hold", hold_err + overlap_err, 0);
    if (ek == 2'd0) begin
      chk(fill_valid, "R9 fill pulse", fill_valid, 1);
      chk(rd_cnt == 2 && wr_cnt == 1, "R8 access count", rd_cnt * 16 + wr_cnt, 33);
      chk(wr_addr == exp_leaf_addr(te, va), "R8 writeback addr", wr_addr, exp_leaf_addr(te, va));
      chk(wr_data == ewb, "R8 writeback data", wr_data, ewb);
      chk(fill_vpn == va[31:12], "R9 fill vpn", fill_vpn, va[31:12]);
      chk(fill_pfn == le[31:12], "R9 fill pfn", fill_pfn, le[31:12]);
      chk(fill_writable == le[1] && fill_dirty == (wr | le[3]), "R9 fill flags",
          {fill_writable, fill_dirty}, {le[1], wr | le[3]});
    end else begin
      chk(fault_valid, "R5/R6/R7 fault pulse", fault_valid, 1);
      chk(fault_kind == ek, ek == 1 ? "R5 kind" : ek == 2 ? "R6 kind" : "R7 kind", fault_kind, ek);
      chk(fault_vaddr == va, "R5 fault vaddr", fault_vaddr, va);
      chk(wr_cnt == 0 && rd_cnt == (ek == 1 ? 1 : 2), "R5/R6/R7 no writeback",
          rd_cnt * 16 + wr_cnt, (ek == 1 ? 16 : 32));
    end
    @(negedge clk);
    chk(walk_ready && !fill_valid && !fault_valid, "R10 idle after pulse",
        {walk_ready, fill_valid, fault_valid}, 3'b100);
  endtask

  function automatic logic [31:0] other_frame(logic [31:0] b, logic [31:0] e);
    if (e[31:12] == b[31:12]) e[12] = ~e[12];
    return e;
  endfunction

  initial begin
    void'($urandom(32'd451));
    repeat (3) @(negedge clk);
    // R1
    chk(walk_ready && !mem_req_valid && !fill_valid && !fault_valid, "R1 reset state",
        {walk_ready, mem_req_valid, fill_valid, fault_valid}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(walk_ready && !mem_req_valid, "R1 after reset", {walk_ready, mem_req_valid}, 2'b10);

    // Directed corner cases
    run_walk(32'h0001_2000, 32'h4080_3abc, 0, 32'h0000_5000, 32'h000a_b003);  // R5
    run_walk(32'h0001_2000, 32'h4080_3abc, 0, 32'h0003_4001, 32'h000a_b002);  // R6
    run_walk(32'h0001_2000, 32'h4080_3abc, 1, 32'h0003_4001, 32'h000a_b001);  // R7 denied
    run_walk(32'h0001_2000, 32'h4080_3abc, 0, 32'h0003_4001, 32'h000a_b001);  // R7 read ok
    run_walk(32'h0001_2000, 32'h4080_3abc, 1, 32'h0003_4001, 32'h000a_b003);  // R8 write
    run_walk(32'h0001_2000, 32'h0000_0000, 0, 32'h0003_4001, 32'hfff0_0009);  // R8 M kept
    run_walk(32'hffff_f000, 32'hffff_ffff, 1, 32'h0000_0fff, 32'h1234_5ff3);  // R2 R3 extremes
    run_walk(32'h0000_0fff, 32'hffc0_0000, 0, 32'h8000_0001, 32'h0000_0001);

    // Random walks
    for (int i = 0; i < 300; i++) begin
      logic [31:0] b, va, te, le;
      b  = $urandom;
      va = $urandom;
      te = other_frame(b, $urandom);
      le = $urandom;
      te[0] = ($urandom % 8) != 0;
      le[0] = ($urandom % 8) != 0;
      run_walk(b, va, $urandom % 2, te, le);
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule